// File: doc/BRIEF.md
# Compare-Output Waveform Unit

This block is an up-counting timer with a set of compare channels (two by default). Each channel holds a compare value and an output flip-flop. When the counter equals the compare value, a match occurs. What the match does to the flip-flop depends on a 2-bit action field for that channel and on the counting mode. A channel's action field can also hand its pin over to the general-purpose port value. The unit produces the resolved pin level and an output-enable for each channel, a match pulse per channel, an overflow pulse, and the live count.

Three counting modes are decoded from a 3-bit mode selector: free-running, clear-on-match (the counter restarts after a channel 0 match), and fast PWM. Fast PWM has two variants: the ceiling is either the all-ones value or the channel 0 compare value. In fast PWM the compare values are double-buffered and refresh when the counter reaches its ceiling. The pin is also set or cleared when the count returns to zero.

The register write port decodes four addresses, listed below. All registers reset to zero.

| Address | Contents |
|---|---|
| 0 | The control byte. Bits 7:6 hold the channel 0 action field, bits 5:4 hold the channel 1 action field, bits 1:0 hold the low mode bits, and bits 3:2 are ignored. |
| 1 | Bit 3 holds the high mode bit. |
| 2 + n | The compare value of channel n. |

Top module: `cmp_wave_unit`

## Requirements
- R1: During and right after reset, the count is 0. Every channel's action field is 00, so each driven pin shows its port bit.
- R2: With mode selector 000 (free-running), the count rises by one per clock and wraps from 0xFF to 0. The overflow pulse is high in the cycle the count is 0xFF.
- R3: With mode selector 010 (clear-on-match), a channel 0 match pulses match bit 0 in the cycle the count equals the channel 0 compare value, and the count is 0 in the next cycle.
- R4: Fast PWM uses mode selector 011 (ceiling 0xFF) or 111 (ceiling equals the channel 0 compare value). The overflow pulse is high in the ceiling cycle, the count is 0 in the next cycle, and it never exceeds the ceiling.
- R5: Outside fast PWM, a match changes the flip-flop in the next cycle. Action field 01 toggles it, 10 clears it and 11 sets it.
- R6: In fast PWM, action field 10 sets the pin when the count wraps to zero and clears it on a match. Action field 11 does the opposite.
- R7: In fast PWM, action field 01 leaves the pin on its port bit when the high mode bit is 0. When the high mode bit is 1, the same field toggles the pin on each match.
- R8: In fast PWM, if the compare value equals the ceiling and the high action bit is set, the match has no effect on the pin. The set or clear at the zero wrap still happens, so the pin stays constantly high (field 10) or low (field 11).
- R9: A channel with action field 00 drives its port bit. Writing ones to control bits 3:2 leaves the counting mode and the channel actions unchanged.
- R10: Each channel's output-enable equals its direction bit. A channel whose direction bit is 0 presents level 0.
- R11: Outside fast PWM, a compare write takes effect from the next cycle. In fast PWM, the written value waits in a buffer and becomes active when the counter wraps at its ceiling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Register address: 0 control, 1 high mode bit, 2+n compare value of channel n |
| wr_data | input | W | Write data |
| pin_dir | input | NCH | Direction bit per channel (1 = driven) |
| port_data | input | NCH | General-purpose port value per channel |
| pin_val | output | NCH | Resolved pin level (0 when not driven) |
| pin_oe | output | NCH | Pin output-enable |
| match_o | output | NCH | Counter equals the channel's active compare value |
| ovf_o | output | 1 | Overflow / ceiling pulse |
| cnt_o | output | W | Current count |

## Verification
The checker watches every cycle for the following:
- The count stepping by one in free-running mode, and returning to zero after the wrap, the clear-on-match point and the fast-PWM ceiling.
- The flip-flop level that follows a clear or set match outside fast PWM.
- The set or clear that follows a fast-PWM wrap.
- The port bit passing through on channels with action field 00.

Only the bench scenarios can show the rest:
- The timing of the compare buffer under fast PWM.
- Disconnection versus toggle for action field 01, which depends on the high mode bit.
- The ignored-match special case, which holds over a whole period.
- That control bits 3:2 are ignored.

// File: rtl/cwu_pkg.sv
package cwu_pkg;

    typedef enum logic [1:0] {
        WV_NORMAL   = 2'd0,
        WV_CTC      = 2'd1,
        WV_FPWM_MAX = 2'd2,
        WV_FPWM_CMP = 2'd3
    } wave_e;

    typedef enum logic [1:0] {
        ACT_NONE   = 2'd0,
        ACT_TOGGLE = 2'd1,
        ACT_CLEAR  = 2'd2,
        ACT_SET    = 2'd3
    } act_e;

    // mode selector {high bit, low bits}
    function automatic wave_e decode_wave(input logic [2:0] sel);
        case (sel)
            3'b010:  return WV_CTC;
            3'b011:  return WV_FPWM_MAX;
            3'b111:  return WV_FPWM_CMP;
            default: return WV_NORMAL;
        endcase
    endfunction

    function automatic logic is_fpwm(input wave_e w);
        return (w == WV_FPWM_MAX) || (w == WV_FPWM_CMP);
    endfunction

    function automatic act_e match_act(input logic [1:0] mode, input logic fpwm,
                                       input logic hi_bit);
        case (mode)
            2'b01:   return (fpwm && !hi_bit) ? ACT_NONE : ACT_TOGGLE;
            2'b10:   return ACT_CLEAR;
            2'b11:   return ACT_SET;
            default: return ACT_NONE;
        endcase
    endfunction

    function automatic act_e bottom_act(input logic [1:0] mode);
        case (mode)
            2'b10:   return ACT_SET;
            2'b11:   return ACT_CLEAR;
            default: return ACT_NONE;
        endcase
    endfunction

    function automatic logic pin_connected(input logic [1:0] mode, input logic fpwm,
                                           input logic hi_bit);
        return (mode != 2'b00) && !(fpwm && mode == 2'b01 && !hi_bit);
    endfunction

    function automatic logic apply_act(input act_e a, input logic cur);
        case (a)
            ACT_TOGGLE: return !cur;
            ACT_CLEAR:  return 1'b0;
            ACT_SET:    return 1'b1;
            default:    return cur;
        endcase
    endfunction

endpackage

// File: rtl/cwu_counter.sv
module cwu_counter #(
    parameter int W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  cwu_pkg::wave_e       wave_i,
    input  logic [W-1:0]         cmp0_i,
    output logic [W-1:0]         cnt_o,
    output logic [W-1:0]         top_o,
    output logic                 at_top_o,
    output logic                 ovf_o
);
    import cwu_pkg::*;

    localparam logic [W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t s_d, s_q;
    logic    fpwm;
    logic    wrap;

    always_comb begin
        s_d      = s_q;
        fpwm     = is_fpwm(wave_i);
        top_o    = (wave_i == WV_FPWM_CMP) ? cmp0_i : CNT_MAX;
        at_top_o = fpwm && (s_q.cnt == top_o);
        wrap     = (wave_i == WV_CTC) ? (s_q.cnt == cmp0_i) : (s_q.cnt == top_o);
        ovf_o    = fpwm ? at_top_o : (s_q.cnt == CNT_MAX);
        s_d.cnt  = wrap ? '0 : s_q.cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cnt_o = s_q.cnt;

endmodule

// File: rtl/cwu_chan.sv
module cwu_chan #(
    parameter int W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_cmp_i,
    input  logic [W-1:0]         wr_data_i,
    input  cwu_pkg::wave_e       wave_i,
    input  logic                 hi_bit_i,
    input  logic [1:0]           mode_i,
    input  logic [W-1:0]         cnt_i,
    input  logic [W-1:0]         top_i,
    input  logic                 at_top_i,
    input  logic                 dir_i,
    input  logic                 port_i,
    output logic [W-1:0]         cmp_act_o,
    output logic                 match_o,
    output logic                 oc_o,
    output logic                 pin_val_o
);
    import cwu_pkg::*;

    typedef struct packed {
        logic [W-1:0] buffer;
        logic [W-1:0] active;
        logic         oc;
    } chan_st_t;

    chan_st_t s_d, s_q;
    logic     fpwm;
    logic     conn;
    act_e     m_act;
    act_e     b_act;

    always_comb begin
        s_d  = s_q;
        fpwm = is_fpwm(wave_i);

        if (wr_cmp_i) begin
            s_d.buffer = wr_data_i;
            if (!fpwm) s_d.active = wr_data_i;
        end
        if (fpwm && at_top_i) s_d.active = s_q.buffer;

        match_o = (cnt_i == s_q.active);
        m_act   = match_act(mode_i, fpwm, hi_bit_i);
        if (fpwm && mode_i[1] && (s_q.active == top_i)) m_act = ACT_NONE;
        b_act   = (fpwm && at_top_i) ? bottom_act(mode_i) : ACT_NONE;

        if (b_act != ACT_NONE)  s_d.oc = apply_act(b_act, s_q.oc);
        else if (match_o)       s_d.oc = apply_act(m_act, s_q.oc);

        conn      = pin_connected(mode_i, fpwm, hi_bit_i);
        pin_val_o = dir_i ? (conn ? s_q.oc : port_i) : 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cmp_act_o = s_q.active;
    assign oc_o      = s_q.oc;

endmodule

// File: rtl/cmp_wave_unit.sv
module cmp_wave_unit #(
    parameter int W   = 8,
    parameter int NCH = 2,
    localparam int AW = $clog2(NCH + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [W-1:0]      wr_data,
    input  logic [NCH-1:0]    pin_dir,
    input  logic [NCH-1:0]    port_data,
    output logic [NCH-1:0]    pin_val,
    output logic [NCH-1:0]    pin_oe,
    output logic [NCH-1:0]    match_o,
    output logic              ovf_o,
    output logic [W-1:0]      cnt_o
);
    import cwu_pkg::*;

    localparam int            CTRL_MSB   = 7;
    localparam int            HI_BIT_POS = 3;
    localparam logic [AW-1:0] ADDR_CTRL  = AW'(0);
    localparam logic [AW-1:0] ADDR_HI    = AW'(1);

    typedef struct packed {
        logic [NCH-1:0][1:0] mode;
        logic [1:0]          wlo;
        logic                hi;
    } ctrl_t;

    ctrl_t               ctrl_d, ctrl_q;
    wave_e               wave;
    logic [NCH-1:0][1:0] mode_v;
    logic [W-1:0]        top_val;
    logic                at_top;
    logic [W-1:0]        cmp_act [NCH];
    logic [NCH-1:0]      oc_v;

    always_comb begin
        ctrl_d = ctrl_q;
        if (wr_en && wr_addr == ADDR_CTRL) begin
            for (int i = 0; i < NCH; i++) ctrl_d.mode[i] = wr_data[CTRL_MSB - 2*i -: 2];
            ctrl_d.wlo = wr_data[1:0];
        end
        if (wr_en && wr_addr == ADDR_HI) ctrl_d.hi = wr_data[HI_BIT_POS];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    assign wave   = decode_wave({ctrl_q.hi, ctrl_q.wlo});
    assign mode_v = ctrl_q.mode;
    assign pin_oe = pin_dir;

    cwu_counter #(.W(W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .wave_i   (wave),
        .cmp0_i   (cmp_act[0]),
        .cnt_o    (cnt_o),
        .top_o    (top_val),
        .at_top_o (at_top),
        .ovf_o    (ovf_o)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        localparam logic [AW-1:0] CMP_ADDR = AW'(2 + g);
        cwu_chan #(.W(W)) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_cmp_i  (wr_en && wr_addr == CMP_ADDR),
            .wr_data_i (wr_data),
            .wave_i    (wave),
            .hi_bit_i  (ctrl_q.hi),
            .mode_i    (ctrl_q.mode[g]),
            .cnt_i     (cnt_o),
            .top_i     (top_val),
            .at_top_i  (at_top),
            .dir_i     (pin_dir[g]),
            .port_i    (port_data[g]),
            .cmp_act_o (cmp_act[g]),
            .match_o   (match_o[g]),
            .oc_o      (oc_v[g]),
            .pin_val_o (pin_val[g])
        );
    end

endmodule

// File: rtl/cwu_checker.sv
module cwu_checker #(
    parameter int W   = 8,
    parameter int NCH = 2
) (
    input logic                clk,
    input logic                rst_n,
    input cwu_pkg::wave_e      wave,
    input logic [NCH-1:0][1:0] mode_v,
    input logic [W-1:0]        cnt,
    input logic                ovf,
    input logic [NCH-1:0]      match,
    input logic [NCH-1:0]      oc,
    input logic [NCH-1:0]      dir,
    input logic [NCH-1:0]      port,
    input logic [NCH-1:0]      pin_val
);
    import cwu_pkg::*;

    logic fpwm;
    assign fpwm = is_fpwm(wave);

    a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (wave == WV_NORMAL && !ovf) |=> cnt == $past(cnt) + 1'b1);

    a_r2_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (wave == WV_NORMAL && ovf) |=> cnt == '0);

    a_r3_ctc_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (wave == WV_CTC && match[0]) |=> cnt == '0);

    a_r4_fpwm_top: assert property (@(posedge clk) disable iff (!rst_n)
        (fpwm && ovf) |=> cnt == '0);

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        a_r5_clear_match: assert property (@(posedge clk) disable iff (!rst_n)
            (!fpwm && mode_v[g] == 2'b10 && match[g]) |=> !oc[g]);

        a_r5_set_match: assert property (@(posedge clk) disable iff (!rst_n)
            (!fpwm && mode_v[g] == 2'b11 && match[g]) |=> oc[g]);

        a_r6_noninv_bottom: assert property (@(posedge clk) disable iff (!rst_n)
            (fpwm && mode_v[g] == 2'b10 && ovf) |=> oc[g]);

        a_r6_inv_bottom: assert property (@(posedge clk) disable iff (!rst_n)
            (fpwm && mode_v[g] == 2'b11 && ovf) |=> !oc[g]);

        a_r9_port_pass: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_v[g] == 2'b00 && dir[g]) |-> pin_val[g] == port[g]);
    end

endmodule

bind cmp_wave_unit cwu_checker #(.W(W), .NCH(NCH)) u_cwu_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wave    (wave),
    .mode_v  (mode_v),
    .cnt     (cnt_o),
    .ovf     (ovf_o),
    .match   (match_o),
    .oc      (oc_v),
    .dir     (pin_dir),
    .port    (port_data),
    .pin_val (pin_val)
);

// File: tb/tb_cmp_wave_unit.sv
module tb_cmp_wave_unit;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       wr_en;
    logic [1:0] wr_addr;
    logic [7:0] wr_data;
    logic [1:0] pin_dir;
    logic [1:0] port_data;
    logic [1:0] pin_val;
    logic [1:0] pin_oe;
    logic [1:0] match_o;
    logic       ovf_o;
    logic [7:0] cnt_o;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    cmp_wave_unit #(.W(8), .NCH(2)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .pin_dir   (pin_dir),
        .port_data (port_data),
        .pin_val   (pin_val),
        .pin_oe    (pin_oe),
        .match_o   (match_o),
        .ovf_o     (ovf_o),
        .cnt_o     (cnt_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    // drive at the current negedge, the register updates at the next posedge
    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_cnt(input logic [7:0] v);
        do @(negedge clk); while (cnt_o !== v);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        pin_dir = 2'b11; port_data = 2'b10;
        repeat (3) @(negedge clk);
        chk("R1 count in reset", cnt_o, 8'h00);
        chk("R1 pins follow port", pin_val, 2'b10);
        chk("R1 overflow low", ovf_o, 1'b0);
        rst_n = 1'b1;
        port_data = 2'b00;
    endtask

    task automatic t_normal();
        wait_cnt(8'hFF);
        chk("R2 overflow at 0xFF", ovf_o, 1'b1);
        @(negedge clk);
        chk("R2 wrap to 0", cnt_o, 8'h00);
        @(negedge clk);
        chk("R2 step", cnt_o, 8'h01);
    endtask

    task automatic t_ctc_toggle();
        logic p;
        wr(2'd2, 8'd10);
        wr(2'd0, 8'b0100_0010);
        wait_cnt(8'd2);
        wr(2'd3, 8'd5);
        wait_cnt(8'd5);
        chk("R11 immediate compare outside PWM", match_o[1], 1'b1);
        wait_cnt(8'd10);
        chk("R3 match pulse", match_o[0], 1'b1);
        p = pin_val[0];
        @(negedge clk);
        chk("R3 clear after match", cnt_o, 8'h00);
        chk("R5 toggle", pin_val[0], !p);
        wait_cnt(8'd10);
        @(negedge clk);
        chk("R5 toggle back", pin_val[0], p);
    endtask

    task automatic t_set_clear();
        wr(2'd0, 8'b0011_0010);
        wait_cnt(8'd5);
        @(negedge clk);
        chk("R5 set on match", pin_val[1], 1'b1);
        wr(2'd0, 8'b0010_1110);
        wait_cnt(8'd5);
        @(negedge clk);
        chk("R5 clear on match", pin_val[1], 1'b0);
        wait_cnt(8'd10);
        @(negedge clk);
        chk("R9 bits 3:2 keep clear-on-match mode", cnt_o, 8'h00);
        port_data = 2'b01; #1;
        chk("R9 field 00 passes port", pin_val[0], 1'b1);
        pin_dir = 2'b10; #1;
        chk("R10 oe follows direction", pin_oe, 2'b10);
        chk("R10 undriven level 0", pin_val[0], 1'b0);
        pin_dir = 2'b11; port_data = 2'b00;
        @(negedge clk);
    endtask

    task automatic t_fpwm();
        wr(2'd0, 8'b0010_0011);
        wait_cnt(8'hFF);
        chk("R4 overflow at ceiling", ovf_o, 1'b1);
        @(negedge clk);
        chk("R4 wrap after ceiling", cnt_o, 8'h00);
        chk("R6 non-inverting set at zero", pin_val[1], 1'b1);
        wait_cnt(8'd5);
        @(negedge clk);
        chk("R6 non-inverting clear on match", pin_val[1], 1'b0);
        wr(2'd0, 8'b0011_0011);
        wait_cnt(8'hFF);
        @(negedge clk);
        chk("R6 inverting clear at zero", pin_val[1], 1'b0);
        wait_cnt(8'd5);
        @(negedge clk);
        chk("R6 inverting set on match", pin_val[1], 1'b1);
        wait_cnt(8'd2);
        wr(2'd3, 8'd60);
        wait_cnt(8'd5);
        chk("R11 old compare still active", match_o[1], 1'b1);
        wait_cnt(8'd60);
        chk("R11 buffered compare not yet active", match_o[1], 1'b0);
        wait_cnt(8'd5);
        chk("R11 old compare retired at ceiling", match_o[1], 1'b0);
        wait_cnt(8'd60);
        chk("R11 buffered compare active", match_o[1], 1'b1);
    endtask

    task automatic t_ceiling_cmp();
        logic p;
        logic bad;
        wr(2'd0, 8'b0100_0011);
        port_data = 2'b01; #1;
        chk("R7 field 01 disconnected high bit 0", pin_val[0], 1'b1);
        port_data = 2'b00; #1;
        chk("R7 field 01 disconnected low", pin_val[0], 1'b0);
        @(negedge clk);
        wr(2'd1, 8'h08);
        wait_cnt(8'd10);
        chk("R4 overflow at compare ceiling", ovf_o, 1'b1);
        p = pin_val[0];
        @(negedge clk);
        chk("R4 wrap after compare ceiling", cnt_o, 8'h00);
        chk("R7 toggle with high bit 1", pin_val[0], !p);
        bad = 1'b0;
        for (int i = 0; i < 24; i++) begin
            @(negedge clk);
            if (cnt_o > 8'd10) bad = 1'b1;
        end
        chk("R4 count stays within ceiling", bad, 1'b0);
        wr(2'd0, 8'b1000_0011);
        wait_cnt(8'd10);
        wait_cnt(8'd1);
        bad = 1'b0;
        for (int i = 0; i < 11; i++) begin
            if (pin_val[0] !== 1'b1) bad = 1'b1;
            @(negedge clk);
        end
        chk("R8 non-inverting stays high", bad, 1'b0);
        wr(2'd0, 8'b1100_0011);
        wait_cnt(8'd10);
        wait_cnt(8'd1);
        bad = 1'b0;
        for (int i = 0; i < 11; i++) begin
            if (pin_val[0] !== 1'b0) bad = 1'b1;
            @(negedge clk);
        end
        chk("R8 inverting stays low", bad, 1'b0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        t_reset();
        t_normal();
        t_ctc_toggle();
        t_set_clear();
        t_fpwm();
        t_ceiling_cmp();
        summary();
        $finish;
    end

endmodule